// File: doc/BRIEF.md
# Virtually-Indexed Physically-Tagged L1 Lookup Stage

This block is the lookup stage of a small read-only, direct-mapped level-one cache. A request carries a virtual address. The set index and the word select are taken straight from the untranslated low bits of that address, so the tag and data arrays are read in the same cycle that an external translation buffer turns the virtual page number into a physical page number. The stored tag is physical. It is compared against the translated page number, together with any page-offset bits that sit above the index. That comparison decides hit or miss.

The outcome is registered and appears one cycle after the request. It is one of three: a hit that carries the selected data word, a miss that also reports the physical line address to be fetched, or a stall when the translation is not yet valid. A separate fill port writes a whole line, its tag and its valid bit into the set chosen by the low bits of a physical line address. With the default geometry of 64 sets of 64-byte lines, the index and the line offset together use 12 bits. This fits inside the 13-bit page offset, so every alias of a physical word selects the same set.

Top module: `vipt_lookup`

## Requirements
- R1: After reset, rsp_valid and miss_valid are low and every set is invalid, so the first translated lookup of any address is a miss.
- R2: Every request produces exactly one of rsp_hit, rsp_miss or rsp_stall together with rsp_valid, one clock cycle after the cycle in which req_valid is high. A cycle without a request yields rsp_valid low and no outcome flag.
- R3: When tlb_valid is low during a request, the response is a stall: rsp_hit, rsp_miss and miss_valid stay low, and the cache contents are not changed.
- R4: A hit occurs when the set selected by vaddr[11:6] is valid and its stored tag equals {tlb_ppn, vaddr[12]}. rsp_data is then the 32-bit word at line bits [32*w +: 32], where w = vaddr[5:2].
- R5: A translated request whose physical page number differs from the stored tag is a miss, and rsp_data is zero on every response that is not a hit.
- R6: On a miss, miss_valid is high in the same cycle as rsp_miss, and miss_line_addr equals {tlb_ppn, vaddr[12:6]}.
- R7: A fill writes fill_line into set fill_line_addr[5:0], stores tag fill_line_addr[25:6] and sets that set's valid bit. Lookups in later cycles hit on it.
- R8: Two virtual addresses with different virtual page numbers, the same page offset and the same physical page number return the same cached word.
- R9: When a fill and a lookup reach the same set in the same cycle, the lookup sees the contents from before the fill.
- R10: A fill into a set that already holds a line replaces it, so the old physical line misses afterwards.
- R11: Addresses that share vaddr[11:6] and a physical page number but differ in vaddr[12] are different lines: a line filled for one misses for the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup request present this cycle |
| req_vaddr | input | 32 | Virtual byte address of the request |
| tlb_valid | input | 1 | Translation for req_vaddr is available this cycle |
| tlb_ppn | input | 19 | Physical page number from the translation buffer |
| rsp_valid | output | 1 | Registered response present |
| rsp_hit | output | 1 | Response is a hit |
| rsp_miss | output | 1 | Response is a miss |
| rsp_stall | output | 1 | Response is a stall: translation was not valid |
| rsp_data | output | 32 | Data word on a hit, zero otherwise |
| miss_valid | output | 1 | A refill is requested for miss_line_addr |
| miss_line_addr | output | 26 | Physical line address of the missing line |
| fill_valid | input | 1 | Write a line into the cache this cycle |
| fill_line_addr | input | 26 | Physical line address of the fill (set in the low bits) |
| fill_line | input | 512 | Full line data, word 0 in the lowest bits |

## Verification
Every lookup result is due on the first rising edge after the cycle in which the request was driven. The bench drives requests on the falling edge and pushes the expected outcome into a queue at that moment. A monitor pops it on the following falling edge, after the capturing edge, so outcome, data and miss address are compared exactly one cycle later. A fill takes effect at the edge that captures it. The bench model applies the fill only after it has computed the expected result of a lookup in the same cycle. Idle cycles are checked on the falling edge that follows the empty edge.

// File: rtl/vipt_pkg.sv
package vipt_pkg;

    // Outcome of one lookup as seen by the response register
    typedef enum logic [1:0] {
        LK_IDLE  = 2'd0,
        LK_HIT   = 2'd1,
        LK_MISS  = 2'd2,
        LK_STALL = 2'd3
    } lookup_kind_e;

endpackage

// File: rtl/vipt_tag_store.sv
module vipt_tag_store #(
    parameter int SETS  = 64,
    parameter int TAG_W = 20,
    localparam int IDX_W = $clog2(SETS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_valid,
    output logic [TAG_W-1:0] rd_tag,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [TAG_W-1:0] wr_tag
);

    logic [SETS-1:0]  valid_d, valid_q;
    logic [TAG_W-1:0] tag_d [SETS];
    logic [TAG_W-1:0] tag_q [SETS];

    always_comb begin
        valid_d = valid_q;
        tag_d   = tag_q;
        if (wr_en) begin
            valid_d[wr_idx] = 1'b1;
            tag_d[wr_idx]   = wr_tag;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
        end else begin
            valid_q <= valid_d;
        end
    end

    always_ff @(posedge clk) begin
        tag_q <= tag_d;
    end

    // Read returns the contents before any same-cycle write
    assign rd_valid = valid_q[rd_idx];
    assign rd_tag   = tag_q[rd_idx];

endmodule

// File: rtl/vipt_data_store.sv
module vipt_data_store #(
    parameter int SETS      = 64,
    parameter int LINE_BITS = 512,
    parameter int WORD_W    = 32,
    localparam int IDX_W    = $clog2(SETS),
    localparam int WORDS    = LINE_BITS / WORD_W,
    localparam int WSEL_W   = $clog2(WORDS)
) (
    input  logic                 clk,
    input  logic [IDX_W-1:0]     rd_idx,
    input  logic [WSEL_W-1:0]    rd_wsel,
    output logic [WORD_W-1:0]    rd_word,
    input  logic                 wr_en,
    input  logic [IDX_W-1:0]     wr_idx,
    input  logic [LINE_BITS-1:0] wr_line
);

    logic [LINE_BITS-1:0] line_q [SETS];
    logic [LINE_BITS-1:0] rd_line;
    logic [WORD_W-1:0]    word_tap [WORDS];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            line_q[wr_idx] <= wr_line;
        end
    end

    assign rd_line = line_q[rd_idx];

    for (genvar w = 0; w < WORDS; w++) begin : g_word
        assign word_tap[w] = rd_line[w*WORD_W +: WORD_W];
    end

    assign rd_word = word_tap[rd_wsel];

endmodule

// File: rtl/vipt_tag_match.sv
module vipt_tag_match
    import vipt_pkg::*;
#(
    parameter int TAG_W = 20
) (
    input  logic             req_valid,
    input  logic             xlat_valid,
    input  logic             entry_valid,
    input  logic [TAG_W-1:0] stored_tag,
    input  logic [TAG_W-1:0] probe_tag,
    output lookup_kind_e     kind
);

    always_comb begin
        if (!req_valid) begin
            kind = LK_IDLE;
        end else if (!xlat_valid) begin
            kind = LK_STALL;
        end else if (entry_valid && (stored_tag == probe_tag)) begin
            kind = LK_HIT;
        end else begin
            kind = LK_MISS;
        end
    end

endmodule

// File: rtl/vipt_lookup.sv
module vipt_lookup
    import vipt_pkg::*;
#(
    parameter int VA_W       = 32,
    parameter int PA_W       = 32,
    parameter int PAGE_OFF_W = 13,
    parameter int LINE_BYTES = 64,
    parameter int SETS       = 64,
    parameter int WORD_W     = 32,
    localparam int OFF_W     = $clog2(LINE_BYTES),
    localparam int IDX_W     = $clog2(SETS),
    localparam int PPN_W     = PA_W - PAGE_OFF_W,
    localparam int SPARE_W   = PAGE_OFF_W - IDX_W - OFF_W,
    localparam int TAG_W     = PPN_W + SPARE_W,
    localparam int LINE_BITS = LINE_BYTES * 8,
    localparam int WORDS     = LINE_BITS / WORD_W,
    localparam int WSEL_W    = $clog2(WORDS),
    localparam int BYTE_W    = $clog2(WORD_W / 8),
    localparam int LADDR_W   = PA_W - OFF_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic [VA_W-1:0]      req_vaddr,
    input  logic                 tlb_valid,
    input  logic [PPN_W-1:0]     tlb_ppn,
    output logic                 rsp_valid,
    output logic                 rsp_hit,
    output logic                 rsp_miss,
    output logic                 rsp_stall,
    output logic [WORD_W-1:0]    rsp_data,
    output logic                 miss_valid,
    output logic [LADDR_W-1:0]   miss_line_addr,
    input  logic                 fill_valid,
    input  logic [LADDR_W-1:0]   fill_line_addr,
    input  logic [LINE_BITS-1:0] fill_line
);

    // Index and offset must stay inside the page offset so aliases share a set
    if (SPARE_W < 0) begin : g_bad_geometry
        initial $error("index plus line offset exceed the page offset");
    end

    typedef struct packed {
        logic               rsp_valid;
        logic               hit;
        logic               miss;
        logic               stall;
        logic [WORD_W-1:0]  data;
        logic               miss_valid;
        logic [LADDR_W-1:0] miss_addr;
    } rsp_state_t;

    rsp_state_t st_d, st_q;

    // Untranslated fields taken from the virtual address
    logic [IDX_W-1:0]  va_idx;
    logic [WSEL_W-1:0] va_wsel;
    logic [TAG_W-1:0]  probe_tag;
    logic [IDX_W-1:0]  fill_idx;
    logic [TAG_W-1:0]  fill_tag;

    assign va_idx   = req_vaddr[OFF_W +: IDX_W];
    assign va_wsel  = req_vaddr[BYTE_W +: WSEL_W];
    assign fill_idx = fill_line_addr[IDX_W-1:0];
    assign fill_tag = fill_line_addr[LADDR_W-1:IDX_W];

    if (SPARE_W > 0) begin : g_spare
        assign probe_tag = {tlb_ppn, req_vaddr[PAGE_OFF_W-1 -: SPARE_W]};
    end else begin : g_no_spare
        assign probe_tag = tlb_ppn;
    end

    logic unused_va_bits;
    assign unused_va_bits = ^{req_vaddr[VA_W-1:PAGE_OFF_W], req_vaddr[BYTE_W-1:0]};

    // Array read in parallel with translation
    logic             ent_valid;
    logic [TAG_W-1:0] ent_tag;
    logic [WORD_W-1:0] ent_word;
    lookup_kind_e      kind;

    vipt_tag_store #(
        .SETS  (SETS),
        .TAG_W (TAG_W)
    ) u_tags (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (va_idx),
        .rd_valid (ent_valid),
        .rd_tag   (ent_tag),
        .wr_en    (fill_valid),
        .wr_idx   (fill_idx),
        .wr_tag   (fill_tag)
    );

    vipt_data_store #(
        .SETS      (SETS),
        .LINE_BITS (LINE_BITS),
        .WORD_W    (WORD_W)
    ) u_data (
        .clk     (clk),
        .rd_idx  (va_idx),
        .rd_wsel (va_wsel),
        .rd_word (ent_word),
        .wr_en   (fill_valid),
        .wr_idx  (fill_idx),
        .wr_line (fill_line)
    );

    vipt_tag_match #(
        .TAG_W (TAG_W)
    ) u_match (
        .req_valid   (req_valid),
        .xlat_valid  (tlb_valid),
        .entry_valid (ent_valid),
        .stored_tag  (ent_tag),
        .probe_tag   (probe_tag),
        .kind        (kind)
    );

    always_comb begin
        st_d            = '0;
        st_d.rsp_valid  = (kind != LK_IDLE);
        st_d.hit        = (kind == LK_HIT);
        st_d.miss       = (kind == LK_MISS);
        st_d.stall      = (kind == LK_STALL);
        st_d.data       = (kind == LK_HIT) ? ent_word : '0;
        st_d.miss_valid = (kind == LK_MISS);
        if (kind == LK_MISS) begin
            st_d.miss_addr = {tlb_ppn, req_vaddr[PAGE_OFF_W-1:OFF_W]};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rsp_valid      = st_q.rsp_valid;
    assign rsp_hit        = st_q.hit;
    assign rsp_miss       = st_q.miss;
    assign rsp_stall      = st_q.stall;
    assign rsp_data       = st_q.data;
    assign miss_valid     = st_q.miss_valid;
    assign miss_line_addr = st_q.miss_addr;

endmodule

// File: rtl/vipt_lookup_chk.sv
module vipt_lookup_chk #(
    parameter int VA_W       = 32,
    parameter int PA_W       = 32,
    parameter int PAGE_OFF_W = 13,
    parameter int LINE_BYTES = 64,
    parameter int WORD_W     = 32,
    localparam int OFF_W     = $clog2(LINE_BYTES),
    localparam int PPN_W     = PA_W - PAGE_OFF_W,
    localparam int LADDR_W   = PA_W - OFF_W
) (
    input logic               clk,
    input logic               rst_n,
    input logic               req_valid,
    input logic [VA_W-1:0]    req_vaddr,
    input logic               tlb_valid,
    input logic [PPN_W-1:0]   tlb_ppn,
    input logic               rsp_valid,
    input logic               rsp_hit,
    input logic               rsp_miss,
    input logic               rsp_stall,
    input logic [WORD_W-1:0]  rsp_data,
    input logic               miss_valid,
    input logic [LADDR_W-1:0] miss_line_addr
);

    // R2: exactly one outcome with every response, none without
    assert_one_outcome_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $onehot({rsp_hit, rsp_miss, rsp_stall}));

    assert_no_outcome_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> !(rsp_hit || rsp_miss || rsp_stall || miss_valid));

    // R2: a response follows a request by exactly one cycle
    assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (rsp_valid == $past(req_valid)));

    // R3: untranslated requests stall and request no refill
    assert_stall_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(req_valid) && !$past(tlb_valid))
            |-> (rsp_stall && !miss_valid));

    // R5: data is zero unless the response is a hit
    assert_zero_data_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_hit |-> (rsp_data == '0));

    // R6: refill request travels with a miss and names the translated line
    assert_miss_pair_R6: assert property (@(posedge clk) disable iff (!rst_n)
        miss_valid == rsp_miss);

    assert_miss_addr_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && miss_valid)
            |-> (miss_line_addr == {$past(tlb_ppn), $past(req_vaddr[PAGE_OFF_W-1:OFF_W])}));

endmodule

bind vipt_lookup vipt_lookup_chk #(
    .VA_W       (VA_W),
    .PA_W       (PA_W),
    .PAGE_OFF_W (PAGE_OFF_W),
    .LINE_BYTES (LINE_BYTES),
    .WORD_W     (WORD_W)
) i_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .req_valid      (req_valid),
    .req_vaddr      (req_vaddr),
    .tlb_valid      (tlb_valid),
    .tlb_ppn        (tlb_ppn),
    .rsp_valid      (rsp_valid),
    .rsp_hit        (rsp_hit),
    .rsp_miss       (rsp_miss),
    .rsp_stall      (rsp_stall),
    .rsp_data       (rsp_data),
    .miss_valid     (miss_valid),
    .miss_line_addr (miss_line_addr)
);

// File: tb/test_vipt_lookup.sv
module test_vipt_lookup;

    localparam time CLK_PERIOD = 10ns;
    localparam int  SETS       = 64;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req_valid = 1'b0;
    logic [31:0]  req_vaddr = '0;
    logic         tlb_valid = 1'b0;
    logic [18:0]  tlb_ppn = '0;
    logic         rsp_valid, rsp_hit, rsp_miss, rsp_stall, miss_valid;
    logic [31:0]  rsp_data;
    logic [25:0]  miss_line_addr;
    logic         fill_valid = 1'b0;
    logic [25:0]  fill_line_addr = '0;
    logic [511:0] fill_line = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    vipt_lookup i_vipt_lookup (
        .clk            (clk),
        .rst_n          (rst_n),
        .req_valid      (req_valid),
        .req_vaddr      (req_vaddr),
        .tlb_valid      (tlb_valid),
        .tlb_ppn        (tlb_ppn),
        .rsp_valid      (rsp_valid),
        .rsp_hit        (rsp_hit),
        .rsp_miss       (rsp_miss),
        .rsp_stall      (rsp_stall),
        .rsp_data       (rsp_data),
        .miss_valid     (miss_valid),
        .miss_line_addr (miss_line_addr),
        .fill_valid     (fill_valid),
        .fill_line_addr (fill_line_addr),
        .fill_line      (fill_line)
    );

    int total = 0;
    int bad   = 0;

    typedef struct {
        logic        hit;
        logic        miss;
        logic        stall;
        logic [31:0] data;
        logic [25:0] maddr;
        string       req;
    } exp_t;

    exp_t sbq[$];

    // Bench model of the cache contents
    logic         m_valid [SETS];
    logic [19:0]  m_tag   [SETS];
    logic [511:0] m_line  [SETS];

    function automatic logic [511:0] mk_line(input logic [15:0] seed);
        logic [511:0] l;
        for (int w = 0; w < 16; w++) begin
            l[w*32 +: 32] = {seed, 16'(w * 16'h1111 + 16'h0F0F)};
        end
        return l;
    endfunction

    function automatic logic [31:0] mk_va(input logic [18:0] vpn, input logic [12:0] off);
        return {vpn, off};
    endfunction

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    task automatic fill_model(input logic [25:0] la, input logic [511:0] line);
        m_valid[la[5:0]] = 1'b1;
        m_tag[la[5:0]]   = la[25:6];
        m_line[la[5:0]]  = line;
    endtask

    // Driver: one request, optionally with a fill in the same cycle
    task automatic lookup(input logic [31:0] va, input logic tv, input logic [18:0] ppn,
                          input string name, input logic do_fill = 1'b0,
                          input logic [25:0] la = '0, input logic [511:0] line = '0);
        exp_t e;
        logic [5:0] set;
        @(negedge clk);
        set     = va[11:6];
        e.req   = name;
        e.hit   = 1'b0;
        e.miss  = 1'b0;
        e.stall = 1'b0;
        e.data  = '0;
        e.maddr = '0;
        if (!tv) begin
            e.stall = 1'b1;
        end else if (m_valid[set] && m_tag[set] == {ppn, va[12]}) begin
            e.hit  = 1'b1;
            e.data = m_line[set][va[5:2]*32 +: 32];
        end else begin
            e.miss  = 1'b1;
            e.maddr = {ppn, va[12:6]};
        end
        sbq.push_back(e);
        req_valid = 1'b1;
        req_vaddr = va;
        tlb_valid = tv;
        tlb_ppn   = ppn;
        if (do_fill) begin
            fill_valid     = 1'b1;
            fill_line_addr = la;
            fill_line      = line;
            fill_model(la, line);  // after the expected value: R9 read-before-write
        end
        @(posedge clk);
        #1;
        req_valid  = 1'b0;
        tlb_valid  = 1'b0;
        fill_valid = 1'b0;
    endtask

    task automatic fill(input logic [25:0] la, input logic [511:0] line);
        @(negedge clk);
        fill_valid     = 1'b1;
        fill_line_addr = la;
        fill_line      = line;
        fill_model(la, line);
        @(posedge clk);
        #1;
        fill_valid = 1'b0;
    endtask

    // R2: a cycle without a request yields no response
    task automatic idle_check();
        @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        total++;
        if (rsp_valid || rsp_hit || rsp_miss || rsp_stall || miss_valid) begin
            bad++;
            $display("FAIL R2 idle: valid=%b hit=%b miss=%b stall=%b mv=%b expected all 0",
                     rsp_valid, rsp_hit, rsp_miss, rsp_stall, miss_valid);
        end
    endtask

    // Monitor: pops one expected item per response
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && rsp_valid) begin
                total++;
                if (sbq.size() == 0) begin
                    bad++;
                    $display("FAIL R2 unexpected response: valid=1 expected 0");
                end else begin
                    exp_t e;
                    e = sbq.pop_front();
                    if (rsp_hit !== e.hit || rsp_miss !== e.miss || rsp_stall !== e.stall ||
                        rsp_data !== e.data || miss_valid !== e.miss ||
                        (e.miss && miss_line_addr !== e.maddr)) begin
                        bad++;
                        $display("FAIL %s: hit=%b miss=%b stall=%b data=%h maddr=%h mv=%b expected hit=%b miss=%b stall=%b data=%h maddr=%h",
                                 e.req, rsp_hit, rsp_miss, rsp_stall, rsp_data, miss_line_addr,
                                 miss_valid, e.hit, e.miss, e.stall, e.data, e.maddr);
                    end
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: run did not end, expected completion");
        finish_run();
    end

    initial begin
        for (int s = 0; s < SETS; s++) begin
            m_valid[s] = 1'b0;
            m_tag[s]   = '0;
            m_line[s]  = '0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        total++;
        if (rsp_valid !== 1'b0 || miss_valid !== 1'b0) begin
            bad++;
            $display("FAIL R1 reset: rsp_valid=%b miss_valid=%b expected 0 0", rsp_valid, miss_valid);
        end
        rst_n = 1'b1;

        // R1 / R6: empty cache misses and reports the physical line
        lookup(mk_va(19'h00123, 13'h00A4), 1'b1, 19'h45678, "R1 R6 first lookup miss");
        // R3: stall while translation is invalid
        lookup(mk_va(19'h00123, 13'h00A4), 1'b0, 19'h45678, "R3 stall");
        // R7: fill then hit on several words (R4)
        fill({19'h45678, 1'b0, 6'd2}, mk_line(16'hA001));
        lookup(mk_va(19'h00123, 13'h00A4), 1'b1, 19'h45678, "R7 R4 hit word 9");
        lookup(mk_va(19'h00123, 13'h00BC), 1'b1, 19'h45678, "R4 hit word 15");
        lookup(mk_va(19'h00123, 13'h0080), 1'b1, 19'h45678, "R4 hit word 0");
        // R8: synonym with another virtual page
        lookup(mk_va(19'h77777, 13'h00A4), 1'b1, 19'h45678, "R8 synonym hit");
        // R5: other physical page misses
        lookup(mk_va(19'h00123, 13'h00A4), 1'b1, 19'h45679, "R5 tag mismatch miss");
        // R11: page-offset bit above the index is part of the tag
        lookup(mk_va(19'h00123, 13'h10A4), 1'b1, 19'h45678, "R11 upper offset bit miss");
        // R3: stall leaves contents unchanged
        lookup(mk_va(19'h00123, 13'h00A4), 1'b0, 19'h00001, "R3 stall other ppn");
        lookup(mk_va(19'h00123, 13'h00A8), 1'b1, 19'h45678, "R3 contents kept after stall");
        idle_check();
        // R10: replacement in a direct-mapped set
        fill({19'h45678, 1'b1, 6'd2}, mk_line(16'hB002));
        lookup(mk_va(19'h00123, 13'h00A4), 1'b1, 19'h45678, "R10 old line evicted");
        lookup(mk_va(19'h00123, 13'h10A4), 1'b1, 19'h45678, "R10 new line hit");
        // R9: fill and lookup on one set in the same cycle
        lookup(mk_va(19'h00123, 13'h10A4), 1'b1, 19'h45678, "R9 same-cycle read old",
               1'b1, {19'h11111, 1'b0, 6'd2}, mk_line(16'hC003));
        lookup(mk_va(19'h00999, 13'h00A4), 1'b1, 19'h11111, "R9 filled line hit next");
        lookup(mk_va(19'h00123, 13'h10A4), 1'b1, 19'h45678, "R9 R10 replaced line miss");
        // R7 / R4: several sets, back-to-back lookups
        for (int s = 8; s < 16; s++) begin
            fill({19'(19'h02000 + s), 1'b0, 6'(s)}, mk_line(16'(16'hD000 + s)));
        end
        for (int s = 8; s < 16; s++) begin
            lookup(mk_va(19'h0ABCD, {1'b0, 6'(s), 6'(4 * (s - 8))}), 1'b1,
                   19'(19'h02000 + s), "R7 R4 burst hit");
        end
        lookup(mk_va(19'h0ABCD, {1'b0, 6'd20, 6'd0}), 1'b1, 19'h02014, "R1 R6 untouched set miss");

        repeat (2) @(negedge clk);
        total++;
        if (sbq.size() != 0) begin
            bad++;
            $display("FAIL R2 missing responses: pending=%0d expected 0", sbq.size());
        end
        finish_run();
    end

endmodule